// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the common and segment drive selections for a multiplexed liquid-crystal panel. The panel runs at 1/4 or 1/8 duty with 1/3 or 1/4 bias. Every output pin carries a small level code rather than a logic level. Code k asks the analog stage outside the block for the voltage VLCD − k·Vop/B, where B is the bias denominator (3 or 4). So code 0 is the top rail and code B is VSS. The dividers and buffers that turn codes into voltages sit elsewhere.

A free-running tick, nominally 32 kHz, paces the sequence. At the start of each common phase the block walks a byte-wide display RAM through its read port, one address per clock. It keeps the bit of each byte that belongs to the new common in a staging register. When the walk is complete, the staged bits and the phase's common index are committed together to the outputs. The host supplies the drive configuration as plain levels: duty, bias, frame rate, blink rate, oscillator run and display enable.

Eight pins serve as commons. The upper four act as extra segments when the panel runs at 1/4 duty. There are NSEG further dedicated segment pins. Blinking blanks every segment during alternate half-periods and leaves the RAM unchanged.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While `rst` is high, and at any time `sys_on` or `disp_on` is low, every code on `cpin_lvl` and `seg_lvl` is 0 (top rail). Codes also stay 0 after the oscillator is enabled until the first RAM walk has been committed.
- R2: While `sys_on` is low, ticks are ignored. When `sys_on` rises, the sequence starts at common 0 of an even frame and the blink phase starts in the shown half.
- R3: Every code driven while the display is on lies in 0..B, with B = 3 when `bias4` is 0 and B = 4 when `bias4` is 1.
- R4: With `duty8` = 0 the duty is 1/4: pins 0..3 are commons, and pins 4..7 are segments that take their data from addresses NSEG..NSEG+3. With `duty8` = 1 the duty is 1/8 and all eight pins are commons. Dedicated segment i always reads address i.
- R5: Bit n of a segment's byte drives that segment during the phase of common n. A 1 bit means on and a 0 bit means off.
- R6: In an even frame the selected common gets code 0 and an unselected common gets B−1. An on segment gets B. An off segment gets 1 at 1/3 bias and 2 at 1/4 bias.
- R7: In an odd frame every code k of R6 becomes B−k. Frames alternate between even and odd.
- R8: With `rate_fast` = 0 a phase lasts TICK_HZ/(80·N) ticks, where N is the number of commons, so one frame spans TICK_HZ/80 ticks. With `rate_fast` = 1 the phase is half as long. Commons are selected in ascending order.
- R9: `blink_sel` 00 means no blinking. Codes 01, 10 and 11 give half-periods of TICK_HZ/4, TICK_HZ/2 and TICK_HZ ticks. The first half is shown. In a blanked half every segment is driven off, and afterwards the unchanged RAM data is shown again.
- R10: Segment data is fetched once per phase. A RAM write made during a phase does not alter that phase's outputs and appears from the next phase that selects the written bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse at the nominal TICK_HZ rate |
| sys_on | input | 1 | Oscillator run; 0 halts and clears the sequence |
| disp_on | input | 1 | Display enable (effective only with sys_on) |
| duty8 | input | 1 | 0 = 1/4 duty, 1 = 1/8 duty |
| bias4 | input | 1 | 0 = 1/3 bias, 1 = 1/4 bias |
| rate_fast | input | 1 | 0 = 80 Hz frame, 1 = 160 Hz frame |
| blink_sel | input | 2 | Blink rate code (00 off, 01 2 Hz, 10 1 Hz, 11 0.5 Hz) |
| ram_addr | output | $clog2(NSEG+4) | Display RAM read address |
| ram_rdata | input | 8 | Byte at ram_addr, same cycle |
| cpin_lvl | output | 8×3 | Level code for each common/shared pin |
| seg_lvl | output | NSEG×3 | Level code for each dedicated segment pin |

## Verification
The states that are hardest to reach from the ports are the odd frame of a given phase and the blanked half-period of the slowest blink code. Both lie hundreds or thousands of ticks after the oscillator is started. The bench makes them reachable by building the block with a much lower TICK_HZ, restarting it before each vector and counting its own ticks. From that count it derives the phase, frame parity and blink half that must be visible at the end. It also rewrites a RAM byte in the middle of a phase to show that the committed data stays latched until the next walk.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    localparam int NPIN     = 8;   // common / shared pins
    localparam int NCOM_MIN = 4;   // pins that are always commons
    localparam int NSHARED  = NPIN - NCOM_MIN;
    localparam int BASE_HZ  = 80;  // slow frame rate
    localparam int LVLW     = 3;

    typedef logic [LVLW-1:0] lvl_t;

    typedef enum logic [1:0] {
        BLK_OFF    = 2'b00,
        BLK_2HZ    = 2'b01,
        BLK_1HZ    = 2'b10,
        BLK_HALFHZ = 2'b11
    } blink_e;

    typedef enum logic [1:0] {
        ROLE_SEL,
        ROLE_UNSEL,
        ROLE_ON,
        ROLE_OFF
    } role_e;

    // Level index (drop from the top rail in steps of Vop/B) for a pin role.
    function automatic lvl_t role_level(role_e role, logic bias4, logic odd);
        lvl_t top_k;
        lvl_t k;
        top_k = bias4 ? lvl_t'(4) : lvl_t'(3);
        unique case (role)
            ROLE_SEL:   k = '0;
            ROLE_UNSEL: k = top_k - lvl_t'(1);
            ROLE_ON:    k = top_k;
            default:    k = bias4 ? lvl_t'(2) : lvl_t'(1);
        endcase
        return odd ? (top_k - k) : k;
    endfunction

endpackage

// File: rtl/lcdseq_phase_timer.sv
module lcdseq_phase_timer
    import lcdseq_pkg::*;
#(
    parameter int TICK_HZ = 32000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       duty8,
    input  logic       fast,
    output logic [2:0] com_idx,
    output logic       odd,
    output logic       adv
);
    localparam int LEN_4S = TICK_HZ / (BASE_HZ * 4);
    localparam int LEN_8S = TICK_HZ / (BASE_HZ * 8);
    localparam int LEN_4F = LEN_4S / 2;
    localparam int LEN_8F = LEN_8S / 2;
    localparam int CW     = $clog2(LEN_4S + 1);

    logic [CW-1:0] tcnt;
    logic [CW-1:0] len;
    logic          last_tick;
    logic          last_com;

    always_comb begin
        unique case ({duty8, fast})
            2'b00:   len = CW'(LEN_4S);
            2'b01:   len = CW'(LEN_4F);
            2'b10:   len = CW'(LEN_8S);
            default: len = CW'(LEN_8F);
        endcase
        last_tick = (tcnt >= len - CW'(1));
        last_com  = duty8 ? (com_idx == 3'd7) : (com_idx >= 3'd3);
        adv       = run && tick && last_tick;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tcnt    <= '0;
            com_idx <= '0;
            odd     <= 1'b0;
        end else if (tick) begin
            if (last_tick) begin
                tcnt    <= '0;
                com_idx <= last_com ? 3'd0 : com_idx + 3'd1;
                if (last_com) odd <= ~odd;
            end else begin
                tcnt <= tcnt + CW'(1);
            end
        end
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !run |=> (tcnt == '0 && com_idx == 3'd0 && !odd)); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        adv |=> (tcnt == '0)); // R8
    AST_FRAME_FLIP: assert property (@(posedge clk) disable iff (rst)
        (adv && last_com) |=> (odd != $past(odd))); // R7

endmodule

// File: rtl/lcdseq_blinker.sv
module lcdseq_blinker
    import lcdseq_pkg::*;
#(
    parameter int TICK_HZ = 32000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   tick,
    input  blink_e sel,
    output logic   blank
);
    localparam int BW = $clog2(TICK_HZ + 1);

    logic [BW-1:0] cnt;
    logic [BW-1:0] half;

    always_comb begin
        unique case (sel)
            BLK_2HZ: half = BW'(TICK_HZ / 4);
            BLK_1HZ: half = BW'(TICK_HZ / 2);
            default: half = BW'(TICK_HZ);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run || sel == BLK_OFF) begin
            cnt   <= '0;
            blank <= 1'b0;
        end else if (tick) begin
            if (cnt >= half - BW'(1)) begin
                cnt   <= '0;
                blank <= ~blank;
            end else begin
                cnt <= cnt + BW'(1);
            end
        end
    end

    AST_BLINK_OFF: assert property (@(posedge clk) disable iff (rst)
        (sel == BLK_OFF) |=> !blank); // R9

endmodule

// File: rtl/lcdseq_col_fetch.sv
module lcdseq_col_fetch #(
    parameter int NADDR = 56,
    localparam int AW   = $clog2(NADDR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             adv,
    input  logic [2:0]       com_idx,
    input  logic             odd,
    input  logic [7:0]       rdata,
    output logic [AW-1:0]    addr,
    output logic [NADDR-1:0] bits,
    output logic [2:0]       sh_com,
    output logic             sh_odd,
    output logic             valid
);
    logic             busy;
    logic             done;
    logic [AW-1:0]    ptr;
    logic [NADDR-1:0] stage;

    assign addr = ptr;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            ptr    <= '0;
            stage  <= '0;
            bits   <= '0;
            sh_com <= '0;
            sh_odd <= 1'b0;
            valid  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                stage[ptr] <= rdata[com_idx];
                if (ptr == AW'(NADDR - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    ptr <= ptr + AW'(1);
                end
            end else if (adv || (!valid && !done)) begin
                busy <= 1'b1;
                ptr  <= '0;
            end
            if (done) begin
                bits   <= stage;
                sh_com <= com_idx;
                sh_odd <= odd;
                valid  <= 1'b1;
            end
        end
    end

    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ptr < AW'(NADDR))); // R5
    AST_COMMIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (done && run) |=> valid); // R10

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
    import lcdseq_pkg::*;
#(
    parameter int TICK_HZ = 32000,
    parameter int NSEG    = 52,
    localparam int NADDR  = NSEG + NSHARED,
    localparam int AW     = $clog2(NADDR)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       sys_on,
    input  logic                       disp_on,
    input  logic                       duty8,
    input  logic                       bias4,
    input  logic                       rate_fast,
    input  logic [1:0]                 blink_sel,
    output logic [AW-1:0]              ram_addr,
    input  logic [7:0]                 ram_rdata,
    output logic [NPIN-1:0][LVLW-1:0]  cpin_lvl,
    output logic [NSEG-1:0][LVLW-1:0]  seg_lvl
);
    logic [2:0]       com_idx;
    logic             odd;
    logic             adv;
    logic             blank;
    logic [NADDR-1:0] bits;
    logic [2:0]       sh_com;
    logic             sh_odd;
    logic             valid;
    logic             show;

    lcdseq_phase_timer #(.TICK_HZ(TICK_HZ)) u_timer (
        .clk(clk), .rst(rst), .run(sys_on), .tick(tick),
        .duty8(duty8), .fast(rate_fast),
        .com_idx(com_idx), .odd(odd), .adv(adv)
    );

    lcdseq_blinker #(.TICK_HZ(TICK_HZ)) u_blink (
        .clk(clk), .rst(rst), .run(sys_on), .tick(tick),
        .sel(blink_e'(blink_sel)), .blank(blank)
    );

    lcdseq_col_fetch #(.NADDR(NADDR)) u_fetch (
        .clk(clk), .rst(rst), .run(sys_on), .adv(adv),
        .com_idx(com_idx), .odd(odd), .rdata(ram_rdata),
        .addr(ram_addr), .bits(bits),
        .sh_com(sh_com), .sh_odd(sh_odd), .valid(valid)
    );

    assign show = sys_on && disp_on && valid;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        role_e role;
        if (p < NCOM_MIN) begin : g_fixed
            assign role = (sh_com == 3'(p)) ? ROLE_SEL : ROLE_UNSEL;
        end else begin : g_shared
            logic on_bit;
            assign on_bit = bits[NSEG + p - NCOM_MIN] & ~blank;
            assign role   = duty8 ? ((sh_com == 3'(p)) ? ROLE_SEL : ROLE_UNSEL)
                                  : (on_bit ? ROLE_ON : ROLE_OFF);
        end
        assign cpin_lvl[p] = show ? role_level(role, bias4, sh_odd) : '0;

        AST_CODE_CEIL: assert property (@(posedge clk) disable iff (rst)
            show |-> (cpin_lvl[p] <= (bias4 ? 3'd4 : 3'd3))); // R3
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        logic on_bit;
        assign on_bit     = bits[i] & ~blank;
        assign seg_lvl[i] = show ? role_level(on_bit ? ROLE_ON : ROLE_OFF, bias4, sh_odd) : '0;
    end

    AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !(sys_on && disp_on) |-> (cpin_lvl == '0 && seg_lvl == '0)); // R1

endmodule

// File: tb/lcd_mux_sequencer_bench.sv
module lcd_mux_sequencer_bench;
    localparam int TICK_HZ = 1280;
    localparam int NSEG    = 6;
    localparam int NADDR   = NSEG + 4;
    localparam int AW      = $clog2(NADDR);
    localparam int TSPACE  = 16;

    logic clk = 1'b0;
    logic rst, tick, sys_on, disp_on, duty8, bias4, rate_fast;
    logic [1:0] blink_sel;
    logic [AW-1:0] ram_addr;
    logic [7:0] ram_rdata;
    logic [7:0][2:0] cpin_lvl;
    logic [NSEG-1:0][2:0] seg_lvl;
    logic [7:0] ram [NADDR];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign ram_rdata = (ram_addr < AW'(NADDR)) ? ram[ram_addr] : 8'h00;

    lcd_mux_sequencer #(.TICK_HZ(TICK_HZ), .NSEG(NSEG)) u_lcd_mux_sequencer (
        .clk(clk), .rst(rst), .tick(tick), .sys_on(sys_on), .disp_on(disp_on),
        .duty8(duty8), .bias4(bias4), .rate_fast(rate_fast), .blink_sel(blink_sel),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .cpin_lvl(cpin_lvl), .seg_lvl(seg_lvl)
    );

    // duty8, bias4, fast, blink code, ticks after start
    typedef struct packed {
        logic d8; logic b4; logic f; logic [1:0] bk; logic [11:0] n;
    } vec_t;
    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b0,2'd0,12'd0},    '{1'b0,1'b0,1'b0,2'd0,12'd5},
        '{1'b0,1'b0,1'b0,2'd0,12'd15},   '{1'b0,1'b0,1'b0,2'd0,12'd16},
        '{1'b0,1'b1,1'b0,2'd0,12'd23},   '{1'b1,1'b0,1'b0,2'd0,12'd7},
        '{1'b1,1'b1,1'b0,2'd0,12'd13},   '{1'b1,1'b1,1'b1,2'd0,12'd9},
        '{1'b0,1'b0,1'b1,2'd0,12'd7},    '{1'b0,1'b0,1'b0,2'd1,12'd320},
        '{1'b0,1'b1,1'b0,2'd1,12'd641},  '{1'b1,1'b0,1'b0,2'd2,12'd650},
        '{1'b0,1'b0,1'b0,2'd3,12'd1279}, '{1'b0,1'b0,1'b1,2'd3,12'd1280}
    };

    // Expected level index from the drive rules (R6, R7).
    function automatic logic [2:0] lvl_for(bit is_com, bit active, bit b4, bit odd);
        int b = b4 ? 4 : 3;
        int k;
        if (is_com) k = active ? 0 : b - 1;
        else        k = active ? b : (b4 ? 2 : 1);
        if (odd) k = b - k;
        return 3'(k);
    endfunction

    task automatic check_all(string tag, bit en, int com, bit odd, bit blank);
        int bad = 0;
        logic [2:0] e;
        logic [2:0] g;
        int where = 0;
        logic [2:0] ge = '0, ee = '0;
        for (int p = 0; p < 8; p++) begin
            bit isc = (p < 4) || duty8;
            bit act = isc ? (p == com) : (ram[NSEG + p - 4][com] && !blank);
            e = en ? lvl_for(isc, act, bias4, odd) : 3'd0;
            g = cpin_lvl[p];
            if (g !== e) begin if (bad == 0) begin where = p; ge = g; ee = e; end bad++; end
        end
        for (int i = 0; i < NSEG; i++) begin
            bit act = ram[i][com] && !blank;
            e = en ? lvl_for(1'b0, act, bias4, odd) : 3'd0;
            g = seg_lvl[i];
            if (g !== e) begin if (bad == 0) begin where = 100 + i; ge = g; ee = e; end bad++; end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: output %0d (>=100 means segment) got %0d expected %0d", tag, where, ge, ee);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ticks(int n);
        for (int t = 0; t < n; t++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; clks(TSPACE - 1);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; sys_on = 1'b0; disp_on = 1'b0; tick = 1'b0;
        clks(2); rst = 1'b0; clks(1);
    endtask

    task automatic expect_state(int n, bit d8, bit f, int bk, output int com, output bit odd, output bit blank);
        int ncom = d8 ? 8 : 4;
        int len  = TICK_HZ / (80 * ncom) / (f ? 2 : 1);
        int ph   = n / len;
        int half = (bk == 1) ? TICK_HZ / 4 : (bk == 2) ? TICK_HZ / 2 : TICK_HZ;
        com   = ph % ncom;
        odd   = ((ph / ncom) % 2) != 0;
        blank = (bk != 0) && ((n / half) % 2 != 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int com; bit odd; bit blank; bit oldb;
        for (int a = 0; a < NADDR; a++) ram[a] = 8'((a * 8'h5B) ^ 8'hA6 ^ (a << 4));
        duty8 = 0; bias4 = 0; rate_fast = 0; blink_sel = 0;
        rst = 1'b1; sys_on = 0; disp_on = 0; tick = 0;
        clks(3);
        // R1: reset state, all pins at top rail
        check_all("R1 reset", 1'b0, 0, 1'b0, 1'b0);
        rst = 1'b0;

        // Table: R4 R5 R6 R7 R8 R9 across modes
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            duty8 = VECS[v].d8; bias4 = VECS[v].b4; rate_fast = VECS[v].f; blink_sel = VECS[v].bk;
            sys_on = 1'b1; disp_on = 1'b1;
            clks(20);
            run_ticks(int'(VECS[v].n));
            expect_state(int'(VECS[v].n), VECS[v].d8, VECS[v].f, int'(VECS[v].bk), com, odd, blank);
            check_all($sformatf("R4/R5/R6/R7/R8/R9 vector %0d", v), 1'b1, com, odd, blank);
        end

        // R1: oscillator on, display off -> dark, then display on shows phase
        do_reset(); duty8 = 0; bias4 = 0; rate_fast = 0; blink_sel = 0;
        sys_on = 1'b1; disp_on = 1'b0; clks(20);
        run_ticks(6);
        check_all("R1 display off", 1'b0, 0, 1'b0, 1'b0);
        disp_on = 1'b1; clks(2);
        check_all("R1 display on", 1'b1, 1, 1'b0, 1'b0);

        // R2: ticks with oscillator stopped are ignored
        do_reset(); disp_on = 1'b1;
        run_ticks(7);
        check_all("R2 stopped dark", 1'b0, 0, 1'b0, 1'b0);
        sys_on = 1'b1; clks(20);
        run_ticks(5);
        check_all("R2 restart from common 0", 1'b1, 1, 1'b0, 1'b0);

        // R10: RAM change mid-phase stays latched until next fetch
        do_reset(); sys_on = 1'b1; disp_on = 1'b1; clks(20);
        run_ticks(1);
        oldb = ram[0][0];
        ram[0] = ram[0] ^ 8'h01;
        clks(4);
        checks++;
        if (seg_lvl[0] !== lvl_for(1'b0, oldb, 1'b0, 1'b0)) begin
            errors++;
            $display("FAIL R10 latched: got %0d expected %0d", seg_lvl[0], lvl_for(1'b0, oldb, 1'b0, 1'b0));
        end
        run_ticks(15);
        check_all("R10 refreshed in odd frame", 1'b1, 0, 1'b1, 1'b0);

        // R9: blink held while blanked, R3 under 1/4 bias odd frame
        do_reset(); bias4 = 1'b1; blink_sel = 2'd1; sys_on = 1'b1; disp_on = 1'b1; clks(20);
        run_ticks(336);
        expect_state(336, 1'b0, 1'b0, 1, com, odd, blank);
        check_all("R9/R3 blanked half", 1'b1, com, odd, blank);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule